// File: doc/BRIEF.md
# Framing Loss Defect Monitor

This block decides when a SONET STS-3 receiver has lost frame and when it has regained it. Once per frame it receives a strobe, a flag that tells whether that frame's A1/A2 alignment bytes arrived without error, and the present state of the severely-errored-frame (SEF) defect. It declares loss of frame (LOF) after SEF has stayed active for a fixed number of consecutive frames. Once LOF is declared, it waits until SEF has gone away. It then counts consecutive frames with clean alignment bytes and clears LOF when that run reaches a programmable threshold.

Every transition of the LOF state, in either direction, latches a change flag into a change-status byte. That byte clears when it is read. A flag latches only from an event: writes to the change-status byte have no effect. The active-low interrupt pin is asserted while any latched flag has its enable bit set. A small register port reaches the live status, the change status, the enable mask and the clearance threshold. Bit 2 is the LOF position in every byte. The other bit positions of the change-status byte are reserved for neighbouring defect sources and read 0 here.

Register addresses (`reg_addr`): 0 = live status (read only), 1 = change status (read clears), 2 = interrupt enable (read/write, 8 bits), 3 = clearance threshold (bits 3..0, read/write).

Top module: `lof_monitor_top`

## Requirements
- R1: After reset, LOF is 0, the change status and the enable mask read 0, `irq_n` is 1, and the threshold at address 3 reads the parameter `RESET_THRESH` (default 8).
- R2: While LOF is 0, LOF becomes 1 on the strobe that completes `DECLARE_FRAMES` consecutive frames with `sef_active`=1. A strobe with `sef_active`=0 restarts that run from zero.
- R3: While LOF is 1, a frame with `sef_active`=1 never clears LOF and resets the good-frame run, even when `framing_ok`=1.
- R4: While LOF is 1, LOF clears on the strobe that completes a run of threshold-many consecutive frames with `sef_active`=0 and `framing_ok`=1. A frame with `framing_ok`=0 resets the run to zero.
- R5: A threshold value of 0 behaves as 1: one good frame after SEF clears is enough to clear LOF.
- R6: Every LOF transition, whether declared or cleared, sets bit 2 of the change status (address 1) one clock after the live bit changes. The other change-status bits read 0. A write to address 1 changes nothing.
- R7: A read of address 1 returns the latched byte and clears it at that clock edge. If a new LOF change arrives in the same cycle as the read, bit 2 stays set.
- R8: `irq_n` is 0 exactly while some change-status bit and the matching enable bit at address 2 are both 1.
- R9: Address 0 reads the live LOF state in bit 2 (1 while declared). Its other bits read 0. LOF changes only on a cycle with `frame_stb`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| framing_ok | input | 1 | This frame's A1/A2 bytes were error-free |
| sef_active | input | 1 | Current SEF defect state |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (causes clear of address 1) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with `DECLARE_FRAMES`=6, so that declaration takes only a few frames and many full declare-and-clear cycles fit in one short run. It keeps the 4-bit threshold and `RESET_THRESH`=8. This reaches the reset value, the zero-means-one case, the largest threshold 15, and runs that are broken one frame short of both the declare count and the clear count. A read of the change-status byte is placed on the very cycle that a change flag arrives, which exercises the no-lost-event rule.

// File: rtl/lof_pkg.sv
package lof_pkg;
    localparam int REG_AW  = 2;
    localparam int REG_DW  = 8;
    localparam int LOF_BIT = 2;

    localparam logic [REG_AW-1:0] ADDR_LIVE = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_CHG  = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_EN   = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_THR  = 2'd3;
endpackage

// File: rtl/lof_fsm.sv
module lof_fsm #(
    parameter int DECLARE_FRAMES = 24,
    parameter int THR_W          = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             framing_ok,
    input  logic             sef_active,
    input  logic [THR_W-1:0] thr,
    output logic             lof,
    output logic             chg
);
    localparam int SEF_W = $clog2(DECLARE_FRAMES + 1);

    typedef struct packed {
        logic             lof;
        logic             chg;
        logic [SEF_W-1:0] sef_cnt;
        logic [THR_W-1:0] good_cnt;
    } fsm_state_t;

    fsm_state_t s_d, s_q;
    logic [THR_W:0] eff_thr;
    logic [THR_W:0] good_next;

    always_comb begin
        eff_thr   = (thr == '0) ? (THR_W+1)'(1) : {1'b0, thr};
        good_next = {1'b0, s_q.good_cnt} + (THR_W+1)'(1);
        s_d       = s_q;
        s_d.chg   = 1'b0;
        if (frame_stb) begin
            if (!s_q.lof) begin
                if (sef_active) begin
                    if (s_q.sef_cnt == SEF_W'(DECLARE_FRAMES - 1)) begin
                        s_d.lof      = 1'b1;
                        s_d.chg      = 1'b1;
                        s_d.sef_cnt  = '0;
                        s_d.good_cnt = '0;
                    end else begin
                        s_d.sef_cnt = s_q.sef_cnt + SEF_W'(1);
                    end
                end else begin
                    s_d.sef_cnt = '0;
                end
            end else begin
                if (sef_active || !framing_ok) begin
                    s_d.good_cnt = '0;
                end else if (good_next >= eff_thr) begin
                    s_d.lof      = 1'b0;
                    s_d.chg      = 1'b1;
                    s_d.good_cnt = '0;
                    s_d.sef_cnt  = '0;
                end else begin
                    s_d.good_cnt = good_next[THR_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lof = s_q.lof;
    assign chg = s_q.chg;

    p_move_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.lof) |-> $past(frame_stb));
    p_declare_needs_sef_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.lof) |-> $past(sef_active));
    p_no_clear_under_sef_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.lof) |-> (!$past(sef_active) && $past(framing_ok)));
    p_chg_marks_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.chg |-> !$stable(s_q.lof));
endmodule

// File: rtl/lof_regs.sv
module lof_regs
    import lof_pkg::*;
#(
    parameter int              THR_W        = 4,
    parameter logic [THR_W-1:0] RESET_THRESH = 4'd8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              lof_live,
    input  logic              lof_chg,
    output logic [REG_DW-1:0] reg_rdata,
    output logic [THR_W-1:0]  thr,
    output logic              irq_n
);
    typedef struct packed {
        logic [REG_DW-1:0] stat;
        logic [REG_DW-1:0] en;
        logic [THR_W-1:0]  thr;
    } reg_state_t;

    reg_state_t r_d, r_q;
    logic rd_clear;
    logic [REG_DW-1:0] events;

    always_comb begin
        rd_clear = reg_rd && (reg_addr == ADDR_CHG);
        events   = '0;
        events[LOF_BIT] = lof_chg;
        r_d = r_q;
        if (rd_clear) r_d.stat = '0;
        r_d.stat = r_d.stat | events;
        if (reg_wr && reg_addr == ADDR_EN)  r_d.en  = reg_wdata;
        if (reg_wr && reg_addr == ADDR_THR) r_d.thr = reg_wdata[THR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.stat <= '0;
            r_q.en   <= '0;
            r_q.thr  <= RESET_THRESH;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_LIVE: reg_rdata[LOF_BIT] = lof_live;
            ADDR_CHG:  reg_rdata = r_q.stat;
            ADDR_EN:   reg_rdata = r_q.en;
            default:   reg_rdata[THR_W-1:0] = r_q.thr;
        endcase
    end

    assign thr   = r_q.thr;
    assign irq_n = ~(|(r_q.stat & r_q.en));

    p_keep_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lof_chg && rd_clear) |=> r_q.stat[LOF_BIT]);
    p_clear_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !lof_chg) |=> (r_q.stat == '0));
    p_irq_on_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lof_chg && r_q.en[LOF_BIT] && !(reg_wr && reg_addr == ADDR_EN)) |=> !irq_n);
    p_event_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lof_chg |=> r_q.stat[LOF_BIT]);
endmodule

// File: rtl/lof_monitor_top.sv
module lof_monitor_top #(
    parameter int         DECLARE_FRAMES = 24,
    parameter logic [3:0] RESET_THRESH   = 4'd8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_stb,
    input  logic       framing_ok,
    input  logic       sef_active,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_n
);
    localparam int THR_W = 4;

    logic             lof_live;
    logic             lof_chg;
    logic [THR_W-1:0] thr;

    lof_fsm #(
        .DECLARE_FRAMES(DECLARE_FRAMES),
        .THR_W         (THR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .framing_ok(framing_ok),
        .sef_active(sef_active),
        .thr       (thr),
        .lof       (lof_live),
        .chg       (lof_chg)
    );

    lof_regs #(
        .THR_W       (THR_W),
        .RESET_THRESH(RESET_THRESH)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .lof_live (lof_live),
        .lof_chg  (lof_chg),
        .reg_rdata(reg_rdata),
        .thr      (thr),
        .irq_n    (irq_n)
    );
endmodule

// File: tb/lof_monitor_top_tb.sv
`timescale 1ns/100ps
module lof_monitor_top_tb;
    localparam int DECL = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0, framing_ok = 1'b0, sef_active = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic irq_n;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    int  m_lof = 0, m_sefrun = 0, m_goodrun = 0, m_chg = 0;
    int  m_stat = 0, m_en = 0, m_thr = 8;

    always #2.5 clk = ~clk;

    lof_monitor_top #(.DECLARE_FRAMES(DECL), .RESET_THRESH(4'd8)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .framing_ok(framing_ok),
        .sef_active(sef_active), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_n(irq_n));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_rdata(input int a);
        case (a)
            0: return m_lof ? 4 : 0;
            1: return m_stat;
            2: return m_en;
            default: return m_thr;
        endcase
    endfunction

    // model update and per-clock comparison
    always @(posedge clk) begin
        int need, nchg;
        if (!rst_n) begin
            m_lof = 0; m_sefrun = 0; m_goodrun = 0; m_chg = 0;
            m_stat = 0; m_en = 0; m_thr = 8;
        end else begin
            nchg = 0;
            if (frame_stb) begin
                if (m_lof == 0) begin
                    if (sef_active) begin
                        m_sefrun++;
                        if (m_sefrun >= DECL) begin
                            m_lof = 1; nchg = 1; m_sefrun = 0; m_goodrun = 0;
                        end
                    end else m_sefrun = 0;
                end else begin
                    need = (m_thr == 0) ? 1 : m_thr;
                    if (sef_active || !framing_ok) m_goodrun = 0;
                    else begin
                        m_goodrun++;
                        if (m_goodrun >= need) begin
                            m_lof = 0; nchg = 1; m_goodrun = 0;
                        end
                    end
                end
            end
            if (reg_rd && reg_addr == 2'd1) m_stat = 0;
            if (m_chg) m_stat = m_stat | 4;
            if (reg_wr && reg_addr == 2'd2) m_en = reg_wdata;
            if (reg_wr && reg_addr == 2'd3) m_thr = reg_wdata & 15;
            m_chg = nchg;
        end
        #2;
        if (rst_n && !done) begin
            chk("R8 irq_n", irq_n, ((m_stat & m_en) != 0) ? 0 : 1);
            case (reg_addr)
                2'd0: chk("R9 live", reg_rdata, exp_rdata(0));
                2'd1: chk("R6 chg", reg_rdata, exp_rdata(1));
                2'd2: chk("R8 en", reg_rdata, exp_rdata(2));
                default: chk("R1 thr", reg_rdata, exp_rdata(3));
            endcase
        end
    end

    task automatic frame(input logic sef, input logic ok);
        @(negedge clk);
        frame_stb = 1'b1; sef_active = sef; framing_ok = ok;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // look at a register without a read strobe
    task automatic peek(input logic [1:0] a, input string req, input int exp);
        @(negedge clk);
        reg_addr = a;
        #1 chk(req, reg_rdata, exp);
    endtask

    task automatic rd(input logic [1:0] a, input string req, input int exp);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 chk(req, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        peek(2'd3, "R1 thr reset", 8);
        peek(2'd0, "R1 lof reset", 0);
        peek(2'd1, "R1 chg reset", 0);
        peek(2'd2, "R1 en reset", 0);
        chk("R1 irq reset", irq_n, 1);
        wr(2'd2, 8'h04);
        wr(2'd3, 8'h03);
        // R2 run broken one short
        for (int i = 0; i < DECL-1; i++) frame(1, 0);
        frame(0, 0);
        for (int i = 0; i < DECL-1; i++) frame(1, 0);
        peek(2'd0, "R2 not yet", 0);
        frame(1, 0);
        peek(2'd0, "R2 declared", 4);
        #1 chk("R8 irq low", irq_n, 0);
        // R6 write to change status has no effect
        wr(2'd1, 8'h00);
        peek(2'd1, "R6 write ignored", 4);
        rd(2'd1, "R6 chg set", 4);
        peek(2'd1, "R7 cleared", 0);
        #1 chk("R8 irq high", irq_n, 1);
        // R3 SEF active blocks clearance
        for (int i = 0; i < 20; i++) frame(1, 1);
        peek(2'd0, "R3 held", 4);
        // R4 run broken by errored frame
        frame(0, 1); frame(0, 1); frame(0, 0);
        frame(0, 1); frame(0, 1);
        peek(2'd0, "R4 still", 4);
        frame(1, 1); frame(0, 1); frame(0, 1);
        peek(2'd0, "R3 sef reset run", 4);
        frame(0, 1);
        peek(2'd0, "R4 cleared", 0);
        // R7 read on the event cycle keeps the bit
        rd(2'd1, "R6 clear flag", 4);
        for (int i = 0; i < DECL-1; i++) frame(1, 0);
        @(negedge clk);
        frame_stb = 1'b1; sef_active = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0; reg_addr = 2'd1; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        peek(2'd1, "R7 kept", 4);
        // R5 threshold zero
        wr(2'd3, 8'hF0);
        peek(2'd3, "R5 thr zero", 0);
        frame(0, 1);
        peek(2'd0, "R5 one frame", 0);
        // threshold 15
        wr(2'd3, 8'h0F);
        for (int i = 0; i < DECL; i++) frame(1, 0);
        for (int i = 0; i < 14; i++) frame(0, 1);
        peek(2'd0, "R4 fourteen", 4);
        frame(0, 1);
        peek(2'd0, "R4 fifteen", 0);
        wr(2'd2, 8'h00);
        peek(2'd2, "R8 en off", 0);
        #1 chk("R8 masked", irq_n, 1);
        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule